// File: doc/BRIEF.md
# Configurable Stream Pipeline Slice

This block sits between a stream producer and a stream consumer that use valid/ready flow control. It cuts timing paths between them. A parameter chooses one of four registration variants:

- **Full:** data, valid and ready are all driven from flops. This is the default.
- **Forward:** only the data and valid path is registered.
- **Reverse:** only the ready path is registered.
- **Bypass:** pure wiring.

Each beat carries the data word plus its sideband: byte keep mask, byte strobe mask, end-of-packet flag, user bits, stream identifier and destination tag. The sideband always travels in the same register stage as the data.

The input data word may be any width. On the way in it is widened to the next whole number of bytes. A second parameter chooses how the new upper bits are filled: copies of the input's top bit (signed), or zeros (unsigned). A 12-bit input therefore leaves as a 16-bit word.

Each variant is a small state machine:
- **Full:** states `SKID_EMPTY`, `SKID_ONE`, `SKID_TWO`.
  - load: `EMPTY→ONE`
  - refill: `ONE→ONE`
  - stall-capture: `ONE→TWO`
  - drain: `ONE→EMPTY`
  - unskid: `TWO→ONE`
- **Forward:** states `FWD_EMPTY` and `FWD_LOADED`.
  - load: `EMPTY→LOADED`
  - pass-through: `LOADED→LOADED`
  - drain: `LOADED→EMPTY`
- **Reverse:** states `REV_PASS` and `REV_HOLD`.
  - capture when the consumer stalls: `PASS→HOLD`
  - release: `HOLD→PASS`
- **Bypass:** no state.

Top module: `axis_reg_slice`

## Requirements
- R1: While reset is applied and right after it, `m_valid` is 0 and `s_ready` is 1 (with `m_ready` held at 1), in every variant.
- R2: `m_data` is `DATA_W` rounded up to a byte multiple. Its low `DATA_W` bits equal the input word. The extra upper bits copy input bit `DATA_W-1` when `SIGNED`=1, and are 0 when `SIGNED`=0.
- R3: `m_keep`, `m_strb`, `m_last`, `m_user`, `m_id` and `m_dest` always leave on the same beat as the data word they entered with.
- R4: In full mode (`MODE`=3, the default) a beat appears one cycle after it is accepted. With `m_ready` held at 1, one beat per cycle is accepted continuously.
- R5: In full mode, with `m_ready` at 0, the slice accepts exactly two beats and then drives `s_ready` to 0.
- R6: In forward mode (`MODE`=1) a beat appears one cycle after acceptance. With `m_ready` at 0, exactly one beat is accepted, and `s_ready` then follows `m_ready` combinationally.
- R7: In reverse mode (`MODE`=2) an accepted beat is visible at the output in the same cycle. With `m_ready` at 0, exactly one beat is captured, and `s_ready` then stays 0 until the next clock edge after the held beat is released.
- R8: In bypass mode (`MODE`=0), `s_ready` equals `m_ready`, and `m_valid` and the payload equal the inputs, in the same cycle. The slice holds no beat.
- R9: While `m_valid` is 1 and `m_ready` is 0, `m_valid` stays 1 and the whole output payload stays unchanged on the next cycle.
- R10: Under any pattern of input gaps and output back-pressure, every accepted beat is delivered exactly once and in acceptance order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| s_valid | input | 1 | Producer offers a beat |
| s_ready | output | 1 | Slice accepts the offered beat |
| s_data | input | DATA_W | Producer data word |
| s_keep | input | BYTE_W/8 | Byte keep mask |
| s_strb | input | BYTE_W/8 | Byte strobe mask |
| s_last | input | 1 | End-of-packet flag |
| s_user | input | USER_W | User sideband |
| s_id | input | ID_W | Stream identifier |
| s_dest | input | DEST_W | Destination tag |
| m_valid | output | 1 | Slice offers a beat |
| m_ready | input | 1 | Consumer accepts the beat |
| m_data | output | BYTE_W | Byte-widened data word |
| m_keep | output | BYTE_W/8 | Byte keep mask |
| m_strb | output | BYTE_W/8 | Byte strobe mask |
| m_last | output | 1 | End-of-packet flag |
| m_user | output | USER_W | User sideband |
| m_id | output | ID_W | Stream identifier |
| m_dest | output | DEST_W | Destination tag |

## Verification
The stall-stability and ready-implies-occupancy properties rely on the producer keeping `s_valid` high, with its payload unchanged, until the beat is accepted. They also rely on the consumer not depending on payload values it has not yet accepted. The stimulus enforces this with a pending flag for each slice: once a beat is offered it is held until a handshake is seen, and only random gaps before a new offer are allowed. Back-pressure is random on each cycle, independently of the producer, so every state-machine transition is reached while the input rules still hold.

// File: rtl/axis_slice_pkg.sv
package axis_slice_pkg;

    typedef enum logic [1:0] {
        MODE_BYPASS = 2'd0,
        MODE_FWD    = 2'd1,
        MODE_REV    = 2'd2,
        MODE_FULL   = 2'd3
    } slice_mode_e;

    typedef enum logic [1:0] {
        SKID_EMPTY = 2'd0,
        SKID_ONE   = 2'd1,
        SKID_TWO   = 2'd2
    } full_state_e;

    typedef enum logic {
        FWD_EMPTY  = 1'b0,
        FWD_LOADED = 1'b1
    } fwd_state_e;

    typedef enum logic {
        REV_PASS = 1'b0,
        REV_HOLD = 1'b1
    } rev_state_e;

    function automatic int round_to_byte(input int bits);
        return ((bits + 7) / 8) * 8;
    endfunction

endpackage

// File: rtl/axis_widen.sv
module axis_widen #(
    parameter int IN_W   = 12,
    parameter int OUT_W  = 16,
    parameter bit SIGNED = 1'b0
) (
    input  logic [IN_W-1:0]  in_word,
    output logic [OUT_W-1:0] out_word
);
    localparam int PAD_W = OUT_W - IN_W;

    generate
        if (PAD_W == 0) begin : g_exact
            assign out_word = in_word;
        end else if (SIGNED) begin : g_sext
            assign out_word = {{PAD_W{in_word[IN_W-1]}}, in_word};
        end else begin : g_zext
            assign out_word = {{PAD_W{1'b0}}, in_word};
        end
    endgenerate
endmodule

// File: rtl/axis_fwd_stage.sv
module axis_fwd_stage
    import axis_slice_pkg::*;
#(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         in_valid,
    output logic         in_ready,
    input  logic [W-1:0] in_data,
    output logic         out_valid,
    input  logic         out_ready,
    output logic [W-1:0] out_data
);
    fwd_state_e state_q, state_d;
    logic [W-1:0] data_q;
    logic load;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= FWD_EMPTY;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)    data_q <= '0;
        else if (load) data_q <= in_data;
    end

    always_comb begin
        state_d   = state_q;
        in_ready  = 1'b1;
        out_valid = 1'b0;
        unique case (state_q)
            FWD_EMPTY: begin
                in_ready = 1'b1;
                if (in_valid) state_d = FWD_LOADED;
            end
            FWD_LOADED: begin
                out_valid = 1'b1;
                in_ready  = out_ready;
                if (out_ready && !in_valid) state_d = FWD_EMPTY;
            end
            default: state_d = FWD_EMPTY;
        endcase
        load     = in_valid && in_ready;
        out_data = data_q;
    end

    assert_stall_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));

    assert_fwd_block_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !in_ready |-> (out_valid && !out_ready));
endmodule

// File: rtl/axis_rev_stage.sv
module axis_rev_stage
    import axis_slice_pkg::*;
#(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         in_valid,
    output logic         in_ready,
    input  logic [W-1:0] in_data,
    output logic         out_valid,
    input  logic         out_ready,
    output logic [W-1:0] out_data
);
    rev_state_e state_q, state_d;
    logic [W-1:0] hold_q;
    logic capture;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= REV_PASS;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       hold_q <= '0;
        else if (capture) hold_q <= in_data;
    end

    always_comb begin
        state_d   = state_q;
        capture   = 1'b0;
        in_ready  = 1'b0;
        out_valid = 1'b0;
        out_data  = in_data;
        unique case (state_q)
            REV_PASS: begin
                in_ready  = 1'b1;
                out_valid = in_valid;
                out_data  = in_data;
                if (in_valid && !out_ready) begin
                    capture = 1'b1;
                    state_d = REV_HOLD;
                end
            end
            REV_HOLD: begin
                out_valid = 1'b1;
                out_data  = hold_q;
                if (out_ready) state_d = REV_PASS;
            end
            default: state_d = REV_PASS;
        endcase
    end

    assert_stall_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));

    assert_rev_occupied_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !in_ready |-> out_valid);
endmodule

// File: rtl/axis_full_stage.sv
module axis_full_stage
    import axis_slice_pkg::*;
#(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         in_valid,
    output logic         in_ready,
    input  logic [W-1:0] in_data,
    output logic         out_valid,
    input  logic         out_ready,
    output logic [W-1:0] out_data
);
    full_state_e state_q, state_d;
    logic [W-1:0] main_q, skid_q;
    logic load_main, load_skid, unskid;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= SKID_EMPTY;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            main_q <= '0;
            skid_q <= '0;
        end else begin
            if (unskid)         main_q <= skid_q;
            else if (load_main) main_q <= in_data;
            if (load_skid)      skid_q <= in_data;
        end
    end

    always_comb begin
        state_d   = state_q;
        load_main = 1'b0;
        load_skid = 1'b0;
        unskid    = 1'b0;
        unique case (state_q)
            SKID_EMPTY: begin
                if (in_valid) begin
                    load_main = 1'b1;
                    state_d   = SKID_ONE;
                end
            end
            SKID_ONE: begin
                if (in_valid && out_ready) begin
                    load_main = 1'b1;
                end else if (in_valid) begin
                    load_skid = 1'b1;
                    state_d   = SKID_TWO;
                end else if (out_ready) begin
                    state_d = SKID_EMPTY;
                end
            end
            SKID_TWO: begin
                if (out_ready) begin
                    unskid  = 1'b1;
                    state_d = SKID_ONE;
                end
            end
            default: state_d = SKID_EMPTY;
        endcase
    end

    always_comb begin
        in_ready  = (state_q != SKID_TWO);
        out_valid = (state_q != SKID_EMPTY);
        out_data  = main_q;
    end

    assert_stall_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));

    assert_full_occupied_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !in_ready |-> out_valid);

    assert_full_latency_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready) |=> out_valid);
endmodule

// File: rtl/axis_reg_slice.sv
module axis_reg_slice
    import axis_slice_pkg::*;
#(
    parameter int          DATA_W = 12,
    parameter int          USER_W = 2,
    parameter int          ID_W   = 2,
    parameter int          DEST_W = 2,
    parameter bit          SIGNED = 1'b0,
    parameter slice_mode_e MODE   = MODE_FULL,
    localparam int         BYTE_W = ((DATA_W + 7) / 8) * 8,
    localparam int         KEEP_W = BYTE_W / 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              s_valid,
    output logic              s_ready,
    input  logic [DATA_W-1:0] s_data,
    input  logic [KEEP_W-1:0] s_keep,
    input  logic [KEEP_W-1:0] s_strb,
    input  logic              s_last,
    input  logic [USER_W-1:0] s_user,
    input  logic [ID_W-1:0]   s_id,
    input  logic [DEST_W-1:0] s_dest,
    output logic              m_valid,
    input  logic              m_ready,
    output logic [BYTE_W-1:0] m_data,
    output logic [KEEP_W-1:0] m_keep,
    output logic [KEEP_W-1:0] m_strb,
    output logic              m_last,
    output logic [USER_W-1:0] m_user,
    output logic [ID_W-1:0]   m_id,
    output logic [DEST_W-1:0] m_dest
);
    localparam int PAY_W = BYTE_W + 2 * KEEP_W + 1 + USER_W + ID_W + DEST_W;

    logic [BYTE_W-1:0] wide_data;
    logic [PAY_W-1:0]  in_pay, out_pay;

    axis_widen #(.IN_W(DATA_W), .OUT_W(BYTE_W), .SIGNED(SIGNED)) u_widen (
        .in_word (s_data),
        .out_word(wide_data)
    );

    assign in_pay = {wide_data, s_keep, s_strb, s_last, s_user, s_id, s_dest};

    generate
        if (MODE == MODE_FULL) begin : g_full
            axis_full_stage #(.W(PAY_W)) u_stage (
                .clk(clk), .rst_n(rst_n),
                .in_valid(s_valid), .in_ready(s_ready), .in_data(in_pay),
                .out_valid(m_valid), .out_ready(m_ready), .out_data(out_pay)
            );
        end else if (MODE == MODE_FWD) begin : g_fwd
            axis_fwd_stage #(.W(PAY_W)) u_stage (
                .clk(clk), .rst_n(rst_n),
                .in_valid(s_valid), .in_ready(s_ready), .in_data(in_pay),
                .out_valid(m_valid), .out_ready(m_ready), .out_data(out_pay)
            );
        end else if (MODE == MODE_REV) begin : g_rev
            axis_rev_stage #(.W(PAY_W)) u_stage (
                .clk(clk), .rst_n(rst_n),
                .in_valid(s_valid), .in_ready(s_ready), .in_data(in_pay),
                .out_valid(m_valid), .out_ready(m_ready), .out_data(out_pay)
            );
        end else begin : g_bypass
            assign s_ready = m_ready;
            assign m_valid = s_valid;
            assign out_pay = in_pay;
        end
    endgenerate

    assign {m_data, m_keep, m_strb, m_last, m_user, m_id, m_dest} = out_pay;
endmodule

// File: tb/test_axis_reg_slice.sv
module test_axis_reg_slice;
    import axis_slice_pkg::*;

    localparam int NI  = 4;
    localparam int DW  = 12;
    localparam int BW  = 16;
    localparam int KW  = 2;
    localparam int PW  = BW + 2 * KW + 1 + 6;

    // {input word, expected signed widening, expected unsigned widening}
    localparam logic [43:0] VEC [16] = '{
        {12'h000, 16'h0000, 16'h0000}, {12'h7FF, 16'h07FF, 16'h07FF},
        {12'h800, 16'hF800, 16'h0800}, {12'hFFF, 16'hFFFF, 16'h0FFF},
        {12'h123, 16'h0123, 16'h0123}, {12'hABC, 16'hFABC, 16'h0ABC},
        {12'h555, 16'h0555, 16'h0555}, {12'hAAA, 16'hFAAA, 16'h0AAA},
        {12'h801, 16'hF801, 16'h0801}, {12'h7FE, 16'h07FE, 16'h07FE},
        {12'h0F0, 16'h00F0, 16'h00F0}, {12'hF0F, 16'hFF0F, 16'h0F0F},
        {12'h400, 16'h0400, 16'h0400}, {12'hC00, 16'hFC00, 16'h0C00},
        {12'h001, 16'h0001, 16'h0001}, {12'hFFE, 16'hFFFE, 16'h0FFE}
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #4 clk = ~clk;

    logic          sv [NI], sr [NI], sl [NI], mv [NI], mr [NI], ml [NI];
    logic [DW-1:0] sd [NI];
    logic [BW-1:0] md [NI];
    logic [KW-1:0] sk [NI], ss [NI], mk [NI], ms [NI];
    logic [1:0]    su [NI], si [NI], sde [NI], mu [NI], mi [NI], mde [NI];

    for (genvar g = 0; g < NI; g++) begin : g_inst
        axis_reg_slice #(
            .DATA_W(DW), .USER_W(2), .ID_W(2), .DEST_W(2),
            .SIGNED((g % 2) == 1), .MODE(slice_mode_e'(g))
        ) i_axis_reg_slice (
            .clk(clk), .rst_n(rst_n),
            .s_valid(sv[g]), .s_ready(sr[g]), .s_data(sd[g]), .s_keep(sk[g]),
            .s_strb(ss[g]), .s_last(sl[g]), .s_user(su[g]), .s_id(si[g]), .s_dest(sde[g]),
            .m_valid(mv[g]), .m_ready(mr[g]), .m_data(md[g]), .m_keep(mk[g]),
            .m_strb(ms[g]), .m_last(ml[g]), .m_user(mu[g]), .m_id(mi[g]), .m_dest(mde[g])
        );
    end

    int n_run = 0, n_fail = 0;
    int sent [NI], rcvd [NI], lim [NI], pf_in [NI];
    bit acc_last [NI], seen_valid [NI], seen_ready [NI];
    logic [PW-1:0] seen_out [NI], snap [NI];
    logic [15:0] lfsr = 16'hACE1;
    bit done = 1'b0;

    function automatic logic [PW-1:0] exp_bus(input int n, input bit sgn);
        logic [43:0] v = VEC[n % 16];
        logic [15:0] w = sgn ? v[31:16] : v[15:0];
        return {w, 2'(n), 2'(n >> 1), 1'((n % 5) == 4), 2'(n >> 2), 2'(n >> 3), 2'(n >> 4)};
    endfunction

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // rmode: 0 = consumer stalls, 1 = consumer always ready, 2 = random both sides
    task automatic step(input int rmode);
        @(negedge clk);
        lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
        for (int k = 0; k < NI; k++) begin
            mr[k] = (rmode == 1) ? 1'b1 : (rmode == 0) ? 1'b0 : lfsr[k];
            if (!sv[k] || acc_last[k])
                sv[k] = ((rmode != 2) || lfsr[k + 8]) && (sent[k] < lim[k]);
            sd[k]  = VEC[sent[k] % 16][43:32];
            sk[k]  = 2'(sent[k]);
            ss[k]  = 2'(sent[k] >> 1);
            sl[k]  = 1'((sent[k] % 5) == 4);
            su[k]  = 2'(sent[k] >> 2);
            si[k]  = 2'(sent[k] >> 3);
            sde[k] = 2'(sent[k] >> 4);
        end
        #2;
        for (int k = 0; k < NI; k++) begin
            seen_valid[k] = mv[k];
            seen_ready[k] = sr[k];
            seen_out[k]   = {md[k], mk[k], ms[k], ml[k], mu[k], mi[k], mde[k]};
            if (mv[k] && mr[k]) begin
                chk(seen_out[k] == exp_bus(rcvd[k], (k % 2) == 1),
                    $sformatf("R2/R3/R10 beat %0d slice %0d", rcvd[k], k),
                    32'(seen_out[k]), 32'(exp_bus(rcvd[k], (k % 2) == 1)));
                rcvd[k]++;
            end
            acc_last[k] = sv[k] && sr[k];
            if (acc_last[k]) begin
                sent[k]++;
                pf_in[k]++;
            end
        end
    endtask

    initial begin
        for (int k = 0; k < NI; k++) begin
            sv[k] = 0; mr[k] = 1; sd[k] = '0; sk[k] = '0; ss[k] = '0; sl[k] = 0;
            su[k] = '0; si[k] = '0; sde[k] = '0;
            sent[k] = 0; rcvd[k] = 0; lim[k] = 0; pf_in[k] = 0; acc_last[k] = 0;
        end
        repeat (3) @(negedge clk);
        #2;
        for (int k = 0; k < NI; k++) begin
            chk(mv[k] == 1'b0, $sformatf("R1 valid in reset slice %0d", k), 32'(mv[k]), 0);
            chk(sr[k] == 1'b1, $sformatf("R1 ready in reset slice %0d", k), 32'(sr[k]), 1);
        end
        @(negedge clk);
        rst_n = 1'b1;
        step(1);
        for (int k = 0; k < NI; k++) begin
            chk(!seen_valid[k] && seen_ready[k], $sformatf("R1 after reset slice %0d", k),
                32'({seen_valid[k], seen_ready[k]}), 32'h1);
        end

        // Latency: one beat with consumer ready.
        for (int k = 0; k < NI; k++) lim[k] = sent[k] + 1;
        step(1);
        chk(seen_valid[0] == 1'b1, "R8 bypass same-cycle valid", 32'(seen_valid[0]), 1);
        chk(seen_valid[1] == 1'b0, "R6 forward one-cycle latency", 32'(seen_valid[1]), 0);
        chk(seen_valid[2] == 1'b1, "R7 reverse same-cycle valid", 32'(seen_valid[2]), 1);
        chk(seen_valid[3] == 1'b0, "R4 full one-cycle latency", 32'(seen_valid[3]), 0);
        step(1);
        chk(seen_valid[1] && seen_valid[3], "R4/R6 beat present next cycle",
            32'({seen_valid[1], seen_valid[3]}), 32'h3);
        repeat (2) step(1);

        // Capacity under a stalled consumer.
        for (int k = 0; k < NI; k++) lim[k] = sent[k] + 4;
        step(0); step(0);
        for (int k = 0; k < NI; k++) snap[k] = seen_out[k];
        repeat (3) step(0);
        chk(sent[0] - rcvd[0] == 0, "R8 bypass holds nothing", 32'(sent[0] - rcvd[0]), 0);
        chk(sent[1] - rcvd[1] == 1, "R6 forward holds one", 32'(sent[1] - rcvd[1]), 1);
        chk(sent[2] - rcvd[2] == 1, "R7 reverse holds one", 32'(sent[2] - rcvd[2]), 1);
        chk(sent[3] - rcvd[3] == 2, "R5 full holds two", 32'(sent[3] - rcvd[3]), 2);
        for (int k = 0; k < NI; k++) begin
            chk(seen_ready[k] == 1'b0, $sformatf("R5/R6/R7/R8 ready low when blocked slice %0d", k),
                32'(seen_ready[k]), 0);
            if (seen_valid[k])
                chk(seen_out[k] == snap[k], $sformatf("R9 stalled output stable slice %0d", k),
                    32'(seen_out[k]), 32'(snap[k]));
        end
        repeat (10) step(1);
        for (int k = 0; k < NI; k++)
            chk(rcvd[k] == lim[k], $sformatf("R10 drain after stall slice %0d", k), rcvd[k], lim[k]);

        // Throughput with consumer always ready.
        for (int k = 0; k < NI; k++) begin
            lim[k] = sent[k] + 20;
            pf_in[k] = 0;
        end
        repeat (20) step(1);
        for (int k = 0; k < NI; k++)
            chk(pf_in[k] == 20, $sformatf("R4 one beat per cycle slice %0d", k), pf_in[k], 20);
        repeat (3) step(1);

        // Random gaps and back-pressure.
        for (int k = 0; k < NI; k++) lim[k] = sent[k] + 300;
        for (int c = 0; c < 4000; c++) begin
            bit all_done = 1'b1;
            step(2);
            for (int k = 0; k < NI; k++) if (rcvd[k] != lim[k]) all_done = 1'b0;
            if (all_done) break;
        end
        for (int k = 0; k < NI; k++) begin
            chk(rcvd[k] == lim[k], $sformatf("R10 random delivered slice %0d", k), rcvd[k], lim[k]);
            chk(sent[k] == lim[k], $sformatf("R10 random accepted slice %0d", k), sent[k], lim[k]);
        end

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        #(8 * 100000);
        if (!done) begin
            n_run++;
            n_fail++;
            $display("FAIL R10 watchdog actual=running expected=finished");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end
endmodule